// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

The engine watches a group of already-synchronized input channels and raises match signals when a configurable boolean pattern is present. Eight bit slices each pick one input channel and test it against a 3-bit condition. Each condition is a constant, a level, a single-cycle edge or an edge that stays remembered. Runs of consecutive slices are ANDed into product terms. A run closes at any slice flagged as an endpoint, and the last slice always closes one.

Software programs three 32-bit words: a source word that holds the channel selects, a configuration word that holds the slice conditions and the endpoint flags, and a control word. The control word turns the engine on, enables a one-clock event pulse, and returns the current per-endpoint match state in its top byte. Match results are registered. They reflect the channel values and the channel history sampled at the previous clock edge.

Top module: `pm_engine`

## Requirements
- R1: After reset the source word reads 0, the configuration word reads 0x0000_0080, the control word reads 0, and match_o and event_o are 0.
- R2: Slice n takes its channel select from source bits [10+3n:8+3n] and its condition from configuration bits [10+3n:8+3n]. Configuration bits 0..6 are the endpoint flags of slices 0..6, and bit 7 always reads 1. Control bit 0 is the engine enable and bit 1 is the event enable. All other bits read 0, except control bits 31:24, which mirror match_o.
- R3: While control bit 0 is 0, match_o stays 0 and event_o stays low, whatever the inputs.
- R4: Condition codes 0 (always true), 4 (channel high), 5 (channel low) and 6 (never true) evaluate the selected channel's current value. The result appears on match_o one clock edge after the inputs are applied.
- R5: match_o[n] is 0 for every slice that is not an endpoint. For an endpoint slice, match_o[n] is the AND of all slices from the one after the previous endpoint up to and including slice n.
- R6: Slice 7 closes a product term even when configuration bits 0..6 are all 0.
- R7: Condition codes 1 (rising), 2 (falling) and 3 (either edge) become true in the cycle the edge is seen and stay true after the edge is gone. They are cleared by any configuration write, or by a control write that switches the engine from off to on.
- R8: Condition code 7 is true only in the cycle in which the selected channel changes, on either edge.
- R9: With control bit 1 set, event_o goes high for exactly one clock each time the OR of all endpoint matches goes from 0 to 1. With control bit 1 clear, event_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | 8 | Synchronized input channels |
| src_we_i | input | 1 | Write strobe for the source word |
| src_wdata_i | input | 32 | Source word write data |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration word write data |
| ctl_we_i | input | 1 | Write strobe for the control word |
| ctl_wdata_i | input | 32 | Control word write data |
| src_o | output | 32 | Source word readback |
| cfg_o | output | 32 | Configuration word readback |
| ctl_o | output | 32 | Control word readback with match state |
| match_o | output | 8 | Per-slice product-term match, endpoints only |
| event_o | output | 1 | One-clock pulse on rising OR of matches |

## Verification
The assertions check four things on every cycle. The outputs stay quiet while the engine is off. An event pulse never lasts longer than one clock and only comes with a match. The constant conditions hold their fixed values. No product term is true unless its own slice is true.

Only the bench scenarios can show the rest. These are the arithmetic of the grouping across every endpoint mask, the level conditions across every channel value, the lifetime of the remembered edges until a configuration write or engine re-entry, and the single-cycle life of the change condition.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    COND_ONE   = 3'd0,
    COND_RISE  = 3'd1,
    COND_FALL  = 3'd2,
    COND_EDGE  = 3'd3,
    COND_HIGH  = 3'd4,
    COND_LOW   = 3'd5,
    COND_ZERO  = 3'd6,
    COND_PULSE = 3'd7
  } cond_e;
endpackage

// File: rtl/pm_slice.sv
module pm_slice
  import pm_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  localparam int SEL_W   = $clog2(NUM_CHAN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic                clear_i,
  input  logic [NUM_CHAN-1:0] chan_i,
  input  logic [NUM_CHAN-1:0] chan_q_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  cond_e               cond_i,
  output logic                hit_o
);
  logic cur, prev, rise, fall, seen, sticky_q;

  assign cur  = chan_i[sel_i];
  assign prev = chan_q_i[sel_i];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
  assign seen = ((cond_i == COND_RISE) & rise) |
                ((cond_i == COND_FALL) & fall) |
                ((cond_i == COND_EDGE) & (rise | fall));

  // remembered edge: survives until reconfiguration or engine re-entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sticky_q <= 1'b0;
    else if (clear_i)           sticky_q <= 1'b0;
    else if (active_i && seen)  sticky_q <= 1'b1;
  end

  always_comb begin
    unique case (cond_i)
      COND_ONE:   hit_o = 1'b1;
      COND_RISE,
      COND_FALL,
      COND_EDGE:  hit_o = sticky_q | seen;
      COND_HIGH:  hit_o = cur;
      COND_LOW:   hit_o = ~cur;
      COND_ZERO:  hit_o = 1'b0;
      COND_PULSE: hit_o = rise | fall;
      default:    hit_o = 1'b0;
    endcase
  end

  assert_const_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == COND_ONE) |-> hit_o);
  assert_const_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == COND_ZERO) |-> !hit_o);
  assert_pulse_needs_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == COND_PULSE && hit_o) |-> (chan_i[sel_i] != chan_q_i[sel_i]));
endmodule

// File: rtl/pm_chain.sv
module pm_chain #(
  parameter int NUM_SLICES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SLICES-1:0] hit_i,
  input  logic [NUM_SLICES-1:0] endp_i,
  output logic [NUM_SLICES-1:0] term_o
);
  always_comb begin
    logic acc;
    acc    = 1'b1;
    term_o = '0;
    for (int n = 0; n < NUM_SLICES; n++) begin
      acc = acc & hit_i[n];
      if (endp_i[n]) begin
        term_o[n] = acc;
        acc       = 1'b1;
      end
    end
  end

  assert_term_needs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o & ~hit_i) == '0);
endmodule

// File: rtl/pm_engine.sv
module pm_engine
  import pm_pkg::*;
#(
  parameter int NUM_SLICES = 8,
  parameter int NUM_CHAN   = 8,
  parameter int REG_W      = 32,
  parameter int FIELD_LSB  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CHAN-1:0]   chan_i,
  input  logic                  src_we_i,
  input  logic [REG_W-1:0]      src_wdata_i,
  input  logic                  cfg_we_i,
  input  logic [REG_W-1:0]      cfg_wdata_i,
  input  logic                  ctl_we_i,
  input  logic [REG_W-1:0]      ctl_wdata_i,
  output logic [REG_W-1:0]      src_o,
  output logic [REG_W-1:0]      cfg_o,
  output logic [REG_W-1:0]      ctl_o,
  output logic [NUM_SLICES-1:0] match_o,
  output logic                  event_o
);
  localparam int FIELD_W    = 3;
  localparam int SEL_W      = $clog2(NUM_CHAN);
  localparam int FIELD_BITS = NUM_SLICES * FIELD_W;

  logic [FIELD_BITS-1:0] src_q, cond_q;
  logic [NUM_SLICES-2:0] endp_q;
  logic                  mode_q, ev_en_q, event_q, clear;
  logic [NUM_CHAN-1:0]   chan_q;
  logic [NUM_SLICES-1:0] hit, endp, term, match_q, match_d;
  logic                  unused_bits;

  assign unused_bits = ^{src_wdata_i[FIELD_LSB-1:0], cfg_wdata_i[NUM_SLICES-1],
                         ctl_wdata_i[REG_W-1:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      cond_q  <= '0;
      endp_q  <= '0;
      mode_q  <= 1'b0;
      ev_en_q <= 1'b0;
    end else begin
      if (src_we_i) src_q <= src_wdata_i[FIELD_LSB +: FIELD_BITS];
      if (cfg_we_i) begin
        cond_q <= cfg_wdata_i[FIELD_LSB +: FIELD_BITS];
        endp_q <= cfg_wdata_i[NUM_SLICES-2:0];
      end
      if (ctl_we_i) begin
        mode_q  <= ctl_wdata_i[0];
        ev_en_q <= ctl_wdata_i[1];
      end
    end
  end

  // edge history is kept whatever the mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_q <= '0;
    else         chan_q <= chan_i;
  end

  assign clear = cfg_we_i | (ctl_we_i & ctl_wdata_i[0] & ~mode_q);
  assign endp  = {1'b1, endp_q};

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    pm_slice #(.NUM_CHAN(NUM_CHAN)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (mode_q),
      .clear_i  (clear),
      .chan_i   (chan_i),
      .chan_q_i (chan_q),
      .sel_i    (src_q[i*FIELD_W +: SEL_W]),
      .cond_i   (cond_e'(cond_q[i*FIELD_W +: FIELD_W])),
      .hit_o    (hit[i])
    );
  end

  pm_chain #(.NUM_SLICES(NUM_SLICES)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .endp_i (endp),
    .term_o (term)
  );

  assign match_d = mode_q ? term : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      event_q <= 1'b0;
    end else begin
      match_q <= match_d;
      event_q <= ev_en_q & (|match_d) & ~(|match_q);
    end
  end

  always_comb begin
    src_o = '0;
    src_o[FIELD_LSB +: FIELD_BITS] = src_q;
    cfg_o = '0;
    cfg_o[FIELD_LSB +: FIELD_BITS] = cond_q;
    cfg_o[NUM_SLICES-1:0] = endp;
    ctl_o = '0;
    ctl_o[1:0] = {ev_en_q, mode_q};
    ctl_o[REG_W-1 -: NUM_SLICES] = match_q;
  end

  assign match_o = match_q;
  assign event_o = event_q;

  assert_off_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |=> (match_o == '0 && !event_o));
  assert_event_one_clock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
  assert_event_with_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (match_o != '0));
endmodule

// File: tb/pm_engine_test.sv
module pm_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  chan_i = '0;
  logic        src_we_i = 1'b0, cfg_we_i = 1'b0, ctl_we_i = 1'b0;
  logic [31:0] src_wdata_i = '0, cfg_wdata_i = '0, ctl_wdata_i = '0;
  logic [31:0] src_o, cfg_o, ctl_o;
  logic [7:0]  match_o;
  logic        event_o;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pm_engine uut (
    .clk_i, .rst_ni, .chan_i,
    .src_we_i, .src_wdata_i, .cfg_we_i, .cfg_wdata_i, .ctl_we_i, .ctl_wdata_i,
    .src_o, .cfg_o, .ctl_o, .match_o, .event_o
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_src(input logic [31:0] v);
    src_we_i = 1'b1; src_wdata_i = v; tick(); src_we_i = 1'b0;
  endtask
  task automatic wr_cfg(input logic [31:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v; tick(); cfg_we_i = 1'b0;
  endtask
  task automatic wr_ctl(input logic [31:0] v);
    ctl_we_i = 1'b1; ctl_wdata_i = v; tick(); ctl_we_i = 1'b0;
  endtask

  function automatic logic [31:0] put(input logic [31:0] w, input int n, input logic [2:0] v);
    w[8+3*n +: 3] = v;
    return w;
  endfunction

  function automatic logic [31:0] cfg_all(input logic [2:0] c, input logic [6:0] ep);
    logic [31:0] w;
    w = {25'd0, ep};
    for (int n = 0; n < 8; n++) w = put(w, n, c);
    return w;
  endfunction

  function automatic logic [7:0] exp_terms(input logic [7:0] hits, input logic [6:0] ep);
    logic       acc;
    logic [7:0] t;
    acc = 1'b1;
    t   = '0;
    for (int n = 0; n < 8; n++) begin
      acc = acc & hits[n];
      if (n == 7 || ep[n]) begin
        t[n] = acc;
        acc  = 1'b1;
      end
    end
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ident;
    logic [7:0]  pats [8] = '{8'hFF, 8'h00, 8'h7E, 8'hF0, 8'h0F, 8'hAA, 8'h55, 8'hFE};
    logic [2:0]  lvl  [4] = '{3'd0, 3'd4, 3'd5, 3'd6};

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R1 reset state
    check("R1 src", src_o, 32'h0);
    check("R1 cfg", cfg_o, 32'h0000_0080);
    check("R1 ctl", ctl_o, 32'h0);
    check("R1 match", {24'd0, match_o}, 32'h0);
    check("R1 event", {31'd0, event_o}, 32'h0);

    // R2 field layout
    wr_src(32'hFFFF_FFFF);
    check("R2 src", src_o, 32'hFFFF_FF00);
    wr_cfg(32'hFFFF_FFFF);
    check("R2 cfg ones", cfg_o, 32'hFFFF_FFFF);
    wr_cfg(32'h0);
    check("R2 cfg zero", cfg_o, 32'h0000_0080);
    wr_ctl(32'hFFFF_FFFF);
    check("R2 ctl low", ctl_o & 32'h00FF_FFFF, 32'h3);
    tick();
    check("R2 ctl mirror", ctl_o, 32'h8000_0003);
    wr_ctl(32'h0);

    ident = '0;
    for (int n = 0; n < 8; n++) ident = put(ident, n, n[2:0]);
    wr_src(ident);

    // R3 engine off: all slices always true, no output
    wr_cfg(cfg_all(3'd0, 7'h7F));
    for (int v = 0; v < 256; v += 37) begin
      chan_i = v[7:0];
      tick();
      check("R3 off match", {24'd0, match_o}, 32'h0);
      check("R3 off event", {31'd0, event_o}, 32'h0);
    end

    // R4 level conditions, every channel value, one slice per term
    wr_ctl(32'h1);
    for (int k = 0; k < 4; k++) begin
      wr_cfg(cfg_all(lvl[k], 7'h7F));
      for (int v = 0; v < 256; v++) begin
        logic [7:0] e;
        chan_i = v[7:0];
        tick();
        case (lvl[k])
          3'd0:    e = 8'hFF;
          3'd4:    e = v[7:0];
          3'd5:    e = ~v[7:0];
          default: e = 8'h00;
        endcase
        check("R4 level", {24'd0, match_o}, {24'd0, e});
        check("R2 mirror", {24'd0, ctl_o[31:24]}, {24'd0, e});
      end
    end

    // R5 / R6 grouping over every endpoint mask
    for (int m = 0; m < 128; m++) begin
      wr_cfg(cfg_all(3'd4, m[6:0]));
      for (int p = 0; p < 8; p++) begin
        chan_i = pats[p];
        tick();
        if (m == 0) check("R6 last endpoint", {24'd0, match_o}, {24'd0, exp_terms(pats[p], 7'h0)});
        else        check("R5 product term", {24'd0, match_o}, {24'd0, exp_terms(pats[p], m[6:0])});
      end
    end

    // R7 rising edge on channel 2 held until reconfigured
    chan_i = 8'h00;
    wr_src(put(32'h0, 0, 3'd2));
    wr_cfg(put(cfg_all(3'd6, 7'h7F), 0, 3'd1));
    tick();
    check("R7 rise idle", {24'd0, match_o}, 32'h0);
    chan_i = 8'h04; tick();
    check("R7 rise seen", {24'd0, match_o}, 32'h1);
    chan_i = 8'h00; tick();
    check("R7 rise held", {24'd0, match_o}, 32'h1);
    tick();
    check("R7 rise still held", {24'd0, match_o}, 32'h1);
    wr_cfg(put(cfg_all(3'd6, 7'h7F), 0, 3'd1));
    tick();
    check("R7 cleared by cfg write", {24'd0, match_o}, 32'h0);
    chan_i = 8'h04; tick();
    check("R7 rise again", {24'd0, match_o}, 32'h1);
    wr_ctl(32'h0);
    wr_ctl(32'h1);
    tick();
    check("R7 cleared by re-entry", {24'd0, match_o}, 32'h0);

    // R7 falling and either edge
    wr_cfg(put(cfg_all(3'd6, 7'h7F), 0, 3'd2));
    tick();
    check("R7 fall idle", {24'd0, match_o}, 32'h0);
    chan_i = 8'h00; tick();
    check("R7 fall seen", {24'd0, match_o}, 32'h1);
    chan_i = 8'h04; tick();
    check("R7 fall held", {24'd0, match_o}, 32'h1);
    wr_cfg(put(cfg_all(3'd6, 7'h7F), 0, 3'd3));
    tick();
    check("R7 either idle", {24'd0, match_o}, 32'h0);
    chan_i = 8'h00; tick();
    check("R7 either seen", {24'd0, match_o}, 32'h1);
    tick();
    check("R7 either held", {24'd0, match_o}, 32'h1);

    // R8 change condition lives for one cycle only
    wr_cfg(put(cfg_all(3'd6, 7'h7F), 0, 3'd7));
    tick();
    check("R8 idle", {24'd0, match_o}, 32'h0);
    chan_i = 8'h04; tick();
    check("R8 rise pulse", {24'd0, match_o}, 32'h1);
    tick();
    check("R8 gone", {24'd0, match_o}, 32'h0);
    chan_i = 8'h00; tick();
    check("R8 fall pulse", {24'd0, match_o}, 32'h1);
    tick();
    check("R8 gone again", {24'd0, match_o}, 32'h0);

    // R9 event output
    wr_src(put(32'h0, 0, 3'd1));
    wr_cfg(put(cfg_all(3'd6, 7'h7F), 0, 3'd4));
    wr_ctl(32'h3);
    tick();
    check("R9 idle", {31'd0, event_o}, 32'h0);
    chan_i = 8'h02; tick();
    check("R9 match", {24'd0, match_o}, 32'h1);
    check("R9 pulse", {31'd0, event_o}, 32'h1);
    tick();
    check("R9 one clock", {31'd0, event_o}, 32'h0);
    chan_i = 8'h00; tick();
    check("R9 no pulse on drop", {31'd0, event_o}, 32'h0);
    chan_i = 8'h02; tick();
    check("R9 second pulse", {31'd0, event_o}, 32'h1);
    chan_i = 8'h00; tick();
    wr_ctl(32'h1);
    chan_i = 8'h02; tick();
    check("R9 disabled match", {24'd0, match_o}, 32'h1);
    check("R9 disabled event", {31'd0, event_o}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule